// File: doc/BRIEF.md
# Processor System Register Bank with Status Word and Condition Evaluator

This block holds the system registers of a 32-bit processor core. Every register sits behind a 5-bit index. The block has one combinational read port and one write port. The write port carries a debug qualifier, so a debugger can reach state that ordinary register-move instructions cannot change. Each index has its own write mask and read-back rule:

- Some indices return fixed identification constants.
- The cause register changes only on debug writes.
- One scratch index turns a negative ordinary write into its magnitude.

The block also holds the packed processor status word (PSW). It drives the whole word out to the execution pipeline. It also evaluates a 4-bit branch condition against the four integer flags, so the branch unit gets a taken/not-taken bit without decoding the flags itself. A constant reset fetch address is provided as well. Exception entry sequencing and the instruction cache are kept out of this block.

Top module: `sysreg_bank`

## Requirements
- R1: The index map is: 0 saved exception PC, 1 saved exception PSW, 2 saved fatal PC, 3 saved fatal PSW, 4 cause register, 5 PSW, 6 identification, 7 task control, 24 cache control, 25 address trap, 29 and 31 scratch, 30 fixed. The read port is combinational. A write lands on the rising clock edge, so a read of the index being written in that same cycle returns the old value.
- R2: A write to the PSW (index 5) or to either saved-PSW register (indices 1 and 3) stores the data ANDed with 0x000FF3FF.
- R3: A write to either saved-PC register (indices 0 and 2) or to the address-trap register (index 25) stores the data with bit 0 forced to zero.
- R4: The cause register (index 4) holds the fatal cause in bits 31:16 and the exception cause in bits 15:0. A write to it changes it only when the debug qualifier is high. Otherwise the register keeps its value.
- R5: Index 6 reads 0x00005346, index 7 reads 0x000000E0 and index 30 reads 0x00000004, whatever has been written to them.
- R6: The cache-control register (index 24) keeps only the enable bit. It reads back as write data bit 1 at bit 1, with every other bit zero.
- R7: Index 29 stores the raw write data. Index 31 stores the raw data on a debug write, and the two's-complement magnitude of the data on an ordinary write. The magnitude of 0x80000000 is 0x80000000.
- R8: While reset is asserted, and after it:
  - the cause register is 0x0000FFF0
  - the PSW is 0x00008000 (NP set)
  - every other writable register is zero
  - the reset-PC output is always 0xFFFFFFF0
- R9: The PSW flags sit at Z bit 0, S bit 1, OV bit 2 and CY bit 3. Condition codes 0 to 7 evaluate to OV, CY, Z, CY|Z, S, 1, OV|S and (OV^S)|Z respectively.
- R10: Condition codes 8 to 15 evaluate to the inverse of code minus 8.
- R11: Indices 8 to 23 and 26 to 28 read as zero and ignore writes.
- R12: The PSW output always equals the value read at index 5, and the condition output follows the current PSW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | 5 | Read index |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_dbg | input | 1 | Debug qualifier for the write |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| cond_code | input | 4 | Branch condition code |
| cond_true | output | 1 | Condition evaluation result |
| psw_o | output | 32 | Current PSW |
| reset_pc | output | 32 | Reset fetch address |

## Verification
Two functions can meet in one cycle.

- **Read during write.** The bench drives the read index equal to the write index during every write cycle. It requires the old value on the read port. After the edge it requires the masked new value.
- **Condition during PSW write.** The bench changes the PSW while a condition code is applied. It judges the condition output against flags it computes itself after each write.

Random writes with random debug qualifiers are checked against a bench model of every index's masking rule. Directed cases cover the magnitude corner at 0x80000000 and all 16 codes across all 16 flag combinations.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 5;
  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IDX_EPC   = 5'd0;
  localparam idx_t IDX_EPSW  = 5'd1;
  localparam idx_t IDX_FPC   = 5'd2;
  localparam idx_t IDX_FPSW  = 5'd3;
  localparam idx_t IDX_CAUSE = 5'd4;
  localparam idx_t IDX_PSW   = 5'd5;
  localparam idx_t IDX_IDENT = 5'd6;
  localparam idx_t IDX_TASK  = 5'd7;
  localparam idx_t IDX_CACHE = 5'd24;
  localparam idx_t IDX_TRAP  = 5'd25;
  localparam idx_t IDX_SCR_A = 5'd29;
  localparam idx_t IDX_FIXED = 5'd30;
  localparam idx_t IDX_SCR_B = 5'd31;

  localparam word_t STATUS_MASK = 32'h000F_F3FF;
  localparam word_t EVEN_MASK   = 32'hFFFF_FFFE;
  localparam word_t IDENT_VAL   = 32'h0000_5346;
  localparam word_t TASK_VAL    = 32'h0000_00E0;
  localparam word_t FIXED_VAL   = 32'h0000_0004;
  localparam word_t CAUSE_RST   = 32'h0000_FFF0;
  localparam word_t PSW_RST     = 32'h0000_8000;
  localparam word_t BOOT_PC     = 32'hFFFF_FFF0;

  localparam int BIT_Z    = 0;
  localparam int BIT_S    = 1;
  localparam int BIT_OV   = 2;
  localparam int BIT_CY   = 3;
  localparam int BIT_CEN  = 1;
  localparam int HALF_W   = XLEN / 2;

  typedef struct packed {
    logic ov;
    logic cy;
    logic z;
    logic s;
  } iflags_t;
endpackage

// File: rtl/sysreg_psw.sv
module sysreg_psw
  import sysreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wdata,
  output word_t psw_q,
  output iflags_t flags
);
  word_t psw_d;

  always_comb begin
    psw_d = psw_q;
    if (we) psw_d = wdata & STATUS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  psw_q <= PSW_RST;
    else if (we) psw_q <= psw_d;
  end

  always_comb begin
    flags.z  = psw_q[BIT_Z];
    flags.s  = psw_q[BIT_S];
    flags.ov = psw_q[BIT_OV];
    flags.cy = psw_q[BIT_CY];
  end

  p_psw_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (psw_q == ($past(wdata) & STATUS_MASK)));
endmodule

// File: rtl/sysreg_cond.sv
module sysreg_cond
  import sysreg_pkg::*;
(
  input  iflags_t    flags,
  input  logic [3:0] code,
  output logic       taken
);
  logic base;

  always_comb begin
    unique case (code[2:0])
      3'd0: base = flags.ov;
      3'd1: base = flags.cy;
      3'd2: base = flags.z;
      3'd3: base = flags.cy | flags.z;
      3'd4: base = flags.s;
      3'd5: base = 1'b1;
      3'd6: base = flags.ov | flags.s;
      default: base = (flags.ov ^ flags.s) | flags.z;
    endcase
    taken = base ^ code[3];
  end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  logic  dbg,
  input  idx_t  widx,
  input  word_t wdata,
  output word_t epc_q,
  output word_t epsw_q,
  output word_t fpc_q,
  output word_t fpsw_q,
  output word_t cause_q,
  output logic  cen_q,
  output word_t trap_q,
  output word_t scra_q,
  output word_t scrb_q
);
  logic  en_epc, en_epsw, en_fpc, en_fpsw, en_cause, en_cen, en_trap, en_scra, en_scrb;
  word_t magnitude, scrb_d;

  always_comb begin
    en_epc   = we && (widx == IDX_EPC);
    en_epsw  = we && (widx == IDX_EPSW);
    en_fpc   = we && (widx == IDX_FPC);
    en_fpsw  = we && (widx == IDX_FPSW);
    en_cause = we && dbg && (widx == IDX_CAUSE);
    en_cen   = we && (widx == IDX_CACHE);
    en_trap  = we && (widx == IDX_TRAP);
    en_scra  = we && (widx == IDX_SCR_A);
    en_scrb  = we && (widx == IDX_SCR_B);
    magnitude = wdata[XLEN-1] ? (~wdata + 1'b1) : wdata;
    scrb_d    = dbg ? wdata : magnitude;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      epsw_q  <= '0;
      fpc_q   <= '0;
      fpsw_q  <= '0;
      cause_q <= CAUSE_RST;
      cen_q   <= 1'b0;
      trap_q  <= '0;
      scra_q  <= '0;
      scrb_q  <= '0;
    end else begin
      if (en_epc)   epc_q   <= wdata & EVEN_MASK;
      if (en_epsw)  epsw_q  <= wdata & STATUS_MASK;
      if (en_fpc)   fpc_q   <= wdata & EVEN_MASK;
      if (en_fpsw)  fpsw_q  <= wdata & STATUS_MASK;
      if (en_cause) cause_q <= wdata;
      if (en_cen)   cen_q   <= wdata[BIT_CEN];
      if (en_trap)  trap_q  <= wdata & EVEN_MASK;
      if (en_scra)  scra_q  <= wdata;
      if (en_scrb)  scrb_q  <= scrb_d;
    end
  end

  p_cause_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !dbg && widx == IDX_CAUSE) |=> $stable(cause_q));
  p_even_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IDX_EPC) |=> (epc_q[0] == 1'b0 && epc_q[XLEN-1:1] == $past(wdata[XLEN-1:1])));
  p_scratch_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IDX_SCR_A) |=> (scra_q == $past(wdata)));
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_idx,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic        wr_dbg,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [3:0]  cond_code,
  output logic        cond_true,
  output logic [31:0] psw_o,
  output logic [31:0] reset_pc
);
  word_t   psw_q, epc_q, epsw_q, fpc_q, fpsw_q, cause_q, trap_q, scra_q, scrb_q;
  logic    cen_q;
  iflags_t flags;
  logic    psw_we;

  assign psw_we = wr_en && (wr_idx == IDX_PSW);

  sysreg_psw u_psw (
    .clk(clk), .rst_n(rst_n), .we(psw_we), .wdata(wr_data),
    .psw_q(psw_q), .flags(flags)
  );

  sysreg_store u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .dbg(wr_dbg), .widx(wr_idx), .wdata(wr_data),
    .epc_q(epc_q), .epsw_q(epsw_q), .fpc_q(fpc_q), .fpsw_q(fpsw_q), .cause_q(cause_q),
    .cen_q(cen_q), .trap_q(trap_q), .scra_q(scra_q), .scrb_q(scrb_q)
  );

  sysreg_cond u_cond (
    .flags(flags), .code(cond_code), .taken(cond_true)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_idx)
      IDX_EPC:   rd_data = epc_q;
      IDX_EPSW:  rd_data = epsw_q;
      IDX_FPC:   rd_data = fpc_q;
      IDX_FPSW:  rd_data = fpsw_q;
      IDX_CAUSE: rd_data = cause_q;
      IDX_PSW:   rd_data = psw_q;
      IDX_IDENT: rd_data = IDENT_VAL;
      IDX_TASK:  rd_data = TASK_VAL;
      IDX_CACHE: rd_data[BIT_CEN] = cen_q;
      IDX_TRAP:  rd_data = trap_q;
      IDX_SCR_A: rd_data = scra_q;
      IDX_FIXED: rd_data = FIXED_VAL;
      IDX_SCR_B: rd_data = scrb_q;
      default:   rd_data = '0;
    endcase
  end

  assign psw_o    = psw_q;
  assign reset_pc = BOOT_PC;

  p_ident_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IDX_IDENT) |-> (rd_data == IDENT_VAL));
  p_cond_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'd5) |-> cond_true);
  p_cond_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'd13) |-> !cond_true);
  p_unassigned_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= 5'd8 && rd_idx <= 5'd23) |-> (rd_data == '0));
endmodule

// File: tb/sim_sysreg_bank.sv
module sim_sysreg_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_idx, wr_idx;
  logic [31:0] rd_data, wr_data, psw_o, reset_pc;
  logic        wr_en, wr_dbg, cond_true;
  logic [3:0]  cond_code;

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_bank u0 (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_dbg(wr_dbg), .wr_idx(wr_idx), .wr_data(wr_data),
    .cond_code(cond_code), .cond_true(cond_true), .psw_o(psw_o), .reset_pc(reset_pc)
  );

  function automatic string req_of(input logic [4:0] i);
    case (i)
      5'd0, 5'd2, 5'd25:       return "R3";
      5'd1, 5'd3, 5'd5:        return "R2";
      5'd4:                    return "R4";
      5'd6, 5'd7, 5'd30:       return "R5";
      5'd24:                   return "R6";
      5'd29, 5'd31:            return "R7";
      default:                 return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] i);
    case (i)
      5'd6:    return 32'h0000_5346;
      5'd7:    return 32'h0000_00E0;
      5'd30:   return 32'h0000_0004;
      default: return mreg[i];
    endcase
  endfunction

  task automatic model_write(input logic [4:0] i, input logic [31:0] d, input logic dbg);
    case (i)
      5'd0, 5'd2, 5'd25: mreg[i] = d & 32'hFFFF_FFFE;
      5'd1, 5'd3, 5'd5:  mreg[i] = d & 32'h000F_F3FF;
      5'd4:              if (dbg) mreg[i] = d;
      5'd24:             mreg[i] = {30'd0, d[1], 1'b0};
      5'd29:             mreg[i] = d;
      5'd31:             mreg[i] = (dbg || !d[31]) ? d : (32'd0 - d);
      default: ;
    endcase
  endtask

  function automatic logic model_cond(input logic [31:0] p, input logic [3:0] c);
    logic z, s, ov, cy, b;
    z = p[0]; s = p[1]; ov = p[2]; cy = p[3];
    case (c[2:0])
      3'd0: b = ov;
      3'd1: b = cy;
      3'd2: b = z;
      3'd3: b = cy | z;
      3'd4: b = s;
      3'd5: b = 1'b1;
      3'd6: b = ov | s;
      default: b = (ov ^ s) | z;
    endcase
    return c[3] ? ~b : b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mreg[4] = 32'h0000_FFF0;
    mreg[5] = 32'h0000_8000;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 32; i++) begin
      rd_idx = i[4:0];
      #1;
      check((tag.len() > 0) ? tag : req_of(i[4:0]), rd_data, model_read(i[4:0]), "read-back");
    end
  endtask

  // Write with same-cycle read of the target index (R1), then read after edge.
  task automatic do_write(input logic [4:0] i, input logic [31:0] d, input logic dbg);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d; wr_dbg = dbg; rd_idx = i;
    #1;
    check("R1", rd_data, model_read(i), "same-cycle read returns old value");
    check("R12", {31'd0, cond_true}, {31'd0, model_cond(mreg[5], cond_code)}, "condition uses old PSW");
    @(negedge clk);
    wr_en = 1'b0;
    model_write(i, d, dbg);
    #1;
    check(req_of(i), rd_data, model_read(i), "value after write");
    check("R12", psw_o, mreg[5], "PSW output");
    check("R12", {31'd0, cond_true}, {31'd0, model_cond(mreg[5], cond_code)}, "condition after write");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_dbg = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = '0; cond_code = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset state, also while asserted
    read_all("R8");
    check("R8", reset_pc, 32'hFFFF_FFF0, "reset PC");
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R8");

    // R5/R11: writes to constants and unassigned indices ignored
    do_write(5'd6, 32'hFFFF_FFFF, 1'b1);
    do_write(5'd7, 32'h0, 1'b0);
    do_write(5'd30, 32'h1234_5678, 1'b1);
    do_write(5'd12, 32'hDEAD_BEEF, 1'b1);
    do_write(5'd27, 32'hCAFE_F00D, 1'b0);
    // R4: cause register debug-only
    do_write(5'd4, 32'h1111_2222, 1'b0);
    do_write(5'd4, 32'hABCD_0123, 1'b1);
    // R7: magnitude corner cases
    do_write(5'd31, 32'hFFFF_FFFF, 1'b0);
    do_write(5'd31, 32'h8000_0000, 1'b0);
    do_write(5'd31, 32'hFFFF_FFFE, 1'b1);
    do_write(5'd29, 32'hF000_000F, 1'b0);
    // R6: cache control
    do_write(5'd24, 32'hFFFF_FFFD, 1'b1);
    do_write(5'd24, 32'h0000_0002, 1'b0);
    // R2/R3: masks
    do_write(5'd5, 32'hFFFF_FFFF, 1'b0);
    do_write(5'd0, 32'hFFFF_FFFF, 1'b0);
    do_write(5'd25, 32'h0000_0003, 1'b0);

    // R9/R10: all codes against all flag combinations
    for (int f = 0; f < 16; f++) begin
      do_write(5'd5, {28'd0, f[3:0]}, 1'b0);
      for (int c = 0; c < 16; c++) begin
        cond_code = c[3:0];
        #1;
        check((c < 8) ? "R9" : "R10", {31'd0, cond_true},
              {31'd0, model_cond(mreg[5], c[3:0])}, "condition code");
      end
    end

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] i;
      i = $urandom_range(0, 31);
      if ($urandom_range(0, 3) == 0) i = 5'd5;
      cond_code = $urandom_range(0, 15);
      do_write(i, $urandom, $urandom_range(0, 1) == 1);
    end
    @(negedge clk);
    read_all("");

    // R8: reset again mid-run
    rst_n = 1'b0;
    #1;
    model_reset();
    read_all("R8");
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule